// File: doc/BRIEF.md
# Command-Sequence Write Protection Unit

This block sits in front of a two-plane nonvolatile memory array and decides, write by write, whether a request may reach the array. Nothing is written until the host has issued an unlock of three command bytes. Each command byte goes to a fixed offset inside the plane it targets, and the top address bit selects that plane. Once the unlock completes, data writes to that plane pass through as a page of bytes. The page lasts until the byte-load window expires, the host aborts it through the write-control input, or a data write goes to the other plane.

If the host adds two more command bytes straight after the unlock, the next write does not go to the array. It loads a block-lock register instead. Each bit of that register guards one of the eight 1K regions, and the region index is taken from the three top address bits. A data write that falls in a locked region is dropped without notice, and a sticky flag records that a drop happened. The lock register resets to a parameter value. The external write-control input suppresses every write while it is high. A rising level on it in the middle of a session throws the session away.

Each accepted write appears one cycle later as a permit pulse, with the address and data that go with it. A write taken as a command appears one cycle later as a consumed pulse.

Top module: `cmd_write_guard`

## Requirements
- R1: After reset, wrPermit, cmdConsumed and dropSticky are 0 and bpReg equals BP_RESET (default 8'h00).
- R2: A data write issued while no unlocked session is open gives neither wrPermit nor cmdConsumed.
- R3: The writes 8'hAA to {p,12'h555}, 8'h55 to {p,12'hAAA} and 8'hA0 to {p,12'h555} each give a cmdConsumed pulse one cycle later and no wrPermit. After them, every data write to plane p gives wrPermit one cycle later, with wrAddrOut and wrDataOut equal to that write. The two outputs are never high together.
- R4: All command bytes of one sequence must carry the same A12 as the first. A data write whose A12 differs from the unlocked plane is not permitted and closes the session.
- R5: A command write that does not match the expected byte and offset is not consumed and not permitted, and the sequence returns to idle.
- R6: A windowTimeout pulse returns the unit to idle. A write in the same cycle as the pulse is judged as if the unit were already idle.
- R7: After the unlock, if the first following write is 8'h55 to {p,12'hAAA} and the next is 8'h80 to {p,12'h555}, both are consumed. The write after that is consumed, not permitted, and loads its data into bpReg. bpReg changes in no other way.
- R8: A data write in an unlocked session whose region index A12..A10 selects a bpReg bit equal to 1 is not permitted and sets dropSticky. Writes to unlocked regions in the same session are still permitted.
- R9: While wrCtrl is 1, no write is permitted or consumed.
- R10: wrCtrl going to 1 during an open session ends it, so a later data write needs a fresh unlock.
- R11: dropSticky, once set, stays 1 until reset.
- R12: After bpReg is loaded the unit is idle, so a data write that follows is not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request strobe, one cycle per byte |
| wrAddr | input | 13 | Write address; bit 12 selects the plane |
| wrData | input | 8 | Write data byte |
| wrCtrl | input | 1 | External write control; high suppresses writes |
| windowTimeout | input | 1 | Pulse marking expiry of the byte-load window |
| wrPermit | output | 1 | Write forwarded to the array (registered pulse) |
| wrAddrOut | output | 13 | Address of the forwarded write |
| wrDataOut | output | 8 | Data of the forwarded write |
| cmdConsumed | output | 1 | Write absorbed as a command or a register load |
| bpReg | output | 8 | Block-lock register, one bit per 1K region |
| dropSticky | output | 1 | Set when a write to a locked region was dropped |

## Verification
A sequencer stuck in the wrong state shows up at the first write after it. A lost unlock leaves wrPermit low one cycle after a data write that should have passed. A session that failed to close lets wrPermit go high for a write that needed a new unlock. A wrong plane latch or a wrong region decode appears as a permit or drop pulse on the wrong address, and dropSticky records the drop. A corrupted lock register can be read directly on bpReg on the cycle after the load.

// File: rtl/cmd_write_guard_pkg.sv
package cmd_write_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SAW1   = 3'd1,
    ST_SAW2   = 3'd2,
    ST_ARMED  = 3'd3,
    ST_PAGE   = 3'd4,
    ST_EXT4   = 3'd5,
    ST_BPOPEN = 3'd6
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic permit;
    logic consume;
    logic loadBp;
    logic latchPlane;
    logic markDrop;
  } strobes_t;

  // datapath -> control
  typedef struct packed {
    logic isFirst;
    logic isSecond;
    logic isThird;
    logic isExt4;
    logic isExt5;
    logic planeMatch;
    logic blockLocked;
  } decode_t;

endpackage

// File: rtl/cmd_write_guard_datapath.sv
module cmd_write_guard_datapath
  import cmd_write_guard_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BLOCK_W = 3,
  parameter logic [DATA_W-1:0] CMD1_DATA = 8'hAA,
  parameter logic [DATA_W-1:0] CMD2_DATA = 8'h55,
  parameter logic [DATA_W-1:0] CMD3_DATA = 8'hA0,
  parameter logic [DATA_W-1:0] EXT4_DATA = 8'h55,
  parameter logic [DATA_W-1:0] EXT5_DATA = 8'h80,
  parameter logic [ADDR_W-2:0] CMD_ADDR_A = 12'h555,
  parameter logic [ADDR_W-2:0] CMD_ADDR_B = 12'hAAA,
  parameter logic [ADDR_W-2:0] EXT4_ADDR = 12'hAAA,
  parameter logic [ADDR_W-2:0] EXT5_ADDR = 12'h555,
  parameter int NUM_BLOCKS = 1 << BLOCK_W,
  parameter logic [NUM_BLOCKS-1:0] BP_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  strobes_t              strobes,
  output decode_t               decode,
  output logic                  wrPermit,
  output logic [ADDR_W-1:0]     wrAddrOut,
  output logic [DATA_W-1:0]     wrDataOut,
  output logic                  cmdConsumed,
  output logic [NUM_BLOCKS-1:0] bpReg,
  output logic                  dropSticky
);

  localparam int OFFS_W = ADDR_W - 1;

  logic              planeReg;
  logic              planeIn;
  logic [OFFS_W-1:0] offsIn;
  logic [BLOCK_W-1:0] blockIdx;

  assign planeIn  = wrAddr[ADDR_W-1];
  assign offsIn   = wrAddr[OFFS_W-1:0];
  assign blockIdx = wrAddr[ADDR_W-1 -: BLOCK_W];

  // Command decode; the first byte may pick either plane, later ones must follow it
  always_comb begin
    decode.planeMatch  = (planeIn == planeReg);
    decode.isFirst     = (wrData == CMD1_DATA) && (offsIn == CMD_ADDR_A);
    decode.isSecond    = decode.planeMatch && (wrData == CMD2_DATA) && (offsIn == CMD_ADDR_B);
    decode.isThird     = decode.planeMatch && (wrData == CMD3_DATA) && (offsIn == CMD_ADDR_A);
    decode.isExt4      = decode.planeMatch && (wrData == EXT4_DATA) && (offsIn == EXT4_ADDR);
    decode.isExt5      = decode.planeMatch && (wrData == EXT5_DATA) && (offsIn == EXT5_ADDR);
    decode.blockLocked = bpReg[blockIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeReg    <= 1'b0;
      bpReg       <= BP_RESET;
      wrPermit    <= 1'b0;
      cmdConsumed <= 1'b0;
      wrAddrOut   <= '0;
      wrDataOut   <= '0;
      dropSticky  <= 1'b0;
    end else begin
      wrPermit    <= strobes.permit;
      cmdConsumed <= strobes.consume;
      if (strobes.latchPlane) planeReg <= planeIn;
      if (strobes.loadBp)     bpReg <= wrData[NUM_BLOCKS-1:0];
      if (strobes.markDrop)   dropSticky <= 1'b1;
      if (strobes.permit) begin
        wrAddrOut <= wrAddr;
        wrDataOut <= wrData;
      end
    end
  end

endmodule

// File: rtl/cmd_write_guard_control.sv
module cmd_write_guard_control
  import cmd_write_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrValid,
  input  logic     wrCtrl,
  input  logic     windowTimeout,
  input  decode_t  decode,
  output strobes_t strobes
);

  seqState_t stateQ, stateEff, stateNext;

  assign stateEff = windowTimeout ? ST_IDLE : stateQ;

  always_comb begin
    strobes   = '0;
    stateNext = stateEff;
    if (wrCtrl) begin
      stateNext = ST_IDLE;
    end else if (wrValid) begin
      unique case (stateEff)
        ST_IDLE: begin
          if (decode.isFirst) begin
            strobes.consume    = 1'b1;
            strobes.latchPlane = 1'b1;
            stateNext          = ST_SAW1;
          end
        end
        ST_SAW1: begin
          strobes.consume = decode.isSecond;
          stateNext       = decode.isSecond ? ST_SAW2 : ST_IDLE;
        end
        ST_SAW2: begin
          strobes.consume = decode.isThird;
          stateNext       = decode.isThird ? ST_ARMED : ST_IDLE;
        end
        ST_ARMED, ST_PAGE: begin
          if (stateEff == ST_ARMED && decode.isExt4) begin
            strobes.consume = 1'b1;
            stateNext       = ST_EXT4;
          end else if (!decode.planeMatch) begin
            stateNext = ST_IDLE;
          end else if (decode.blockLocked) begin
            strobes.markDrop = 1'b1;
            stateNext        = ST_PAGE;
          end else begin
            strobes.permit = 1'b1;
            stateNext      = ST_PAGE;
          end
        end
        ST_EXT4: begin
          strobes.consume = decode.isExt5;
          stateNext       = decode.isExt5 ? ST_BPOPEN : ST_IDLE;
        end
        ST_BPOPEN: begin
          strobes.consume = 1'b1;
          strobes.loadBp  = 1'b1;
          stateNext       = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

endmodule

// File: rtl/cmd_write_guard.sv
module cmd_write_guard
  import cmd_write_guard_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BLOCK_W = 3,
  parameter logic [DATA_W-1:0] EXT4_DATA = 8'h55,
  parameter logic [DATA_W-1:0] EXT5_DATA = 8'h80,
  parameter logic [ADDR_W-2:0] EXT4_ADDR = 12'hAAA,
  parameter logic [ADDR_W-2:0] EXT5_ADDR = 12'h555,
  parameter int NUM_BLOCKS = 1 << BLOCK_W,
  parameter logic [NUM_BLOCKS-1:0] BP_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  wrCtrl,
  input  logic                  windowTimeout,
  output logic                  wrPermit,
  output logic [ADDR_W-1:0]     wrAddrOut,
  output logic [DATA_W-1:0]     wrDataOut,
  output logic                  cmdConsumed,
  output logic [NUM_BLOCKS-1:0] bpReg,
  output logic                  dropSticky
);

  strobes_t strobes;
  decode_t  decode;

  cmd_write_guard_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .wrValid       (wrValid),
    .wrCtrl        (wrCtrl),
    .windowTimeout (windowTimeout),
    .decode        (decode),
    .strobes       (strobes)
  );

  cmd_write_guard_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BLOCK_W    (BLOCK_W),
    .EXT4_DATA  (EXT4_DATA),
    .EXT5_DATA  (EXT5_DATA),
    .EXT4_ADDR  (EXT4_ADDR),
    .EXT5_ADDR  (EXT5_ADDR),
    .NUM_BLOCKS (NUM_BLOCKS),
    .BP_RESET   (BP_RESET)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strobes     (strobes),
    .decode      (decode),
    .wrPermit    (wrPermit),
    .wrAddrOut   (wrAddrOut),
    .wrDataOut   (wrDataOut),
    .cmdConsumed (cmdConsumed),
    .bpReg       (bpReg),
    .dropSticky  (dropSticky)
  );

endmodule

// File: rtl/cmd_write_guard_checker.sv
module cmd_write_guard_checker #(
  parameter int ADDR_W = 13,
  parameter int BLOCK_W = 3,
  parameter int NUM_BLOCKS = 1 << BLOCK_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrValid,
  input logic                  wrCtrl,
  input logic                  wrPermit,
  input logic [ADDR_W-1:0]     wrAddrOut,
  input logic                  cmdConsumed,
  input logic [NUM_BLOCKS-1:0] bpReg,
  input logic                  dropSticky
);

  AST_PERMIT_CONSUME_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPermit && cmdConsumed)); // R3

  AST_NO_REQ_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !wrPermit && !cmdConsumed); // R2

  AST_WC_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> !wrPermit && !cmdConsumed); // R9

  AST_LOCK_HONORED: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> !bpReg[wrAddrOut[ADDR_W-1 -: BLOCK_W]]); // R8

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    dropSticky |=> dropSticky); // R11

  AST_BP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdConsumed |-> $stable(bpReg)); // R7

endmodule

bind cmd_write_guard cmd_write_guard_checker #(
  .ADDR_W     (ADDR_W),
  .BLOCK_W    (BLOCK_W),
  .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrValid     (wrValid),
  .wrCtrl      (wrCtrl),
  .wrPermit    (wrPermit),
  .wrAddrOut   (wrAddrOut),
  .cmdConsumed (cmdConsumed),
  .bpReg       (bpReg),
  .dropSticky  (dropSticky)
);

// File: tb/cmd_write_guard_bench.sv
module cmd_write_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrCtrl = 1'b0;
  logic        windowTimeout = 1'b0;
  logic        wrPermit;
  logic [12:0] wrAddrOut;
  logic [7:0]  wrDataOut;
  logic        cmdConsumed;
  logic [7:0]  bpReg;
  logic        dropSticky;

  int checks = 0;
  int errors = 0;
  logic gotPermit, gotConsumed;

  always #2 clk = ~clk;

  cmd_write_guard u_cmd_write_guard (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrCtrl(wrCtrl), .windowTimeout(windowTimeout), .wrPermit(wrPermit),
    .wrAddrOut(wrAddrOut), .wrDataOut(wrDataOut), .cmdConsumed(cmdConsumed),
    .bpReg(bpReg), .dropSticky(dropSticky)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write; outputs sampled on the following falling edge
  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic to = 1'b0);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; windowTimeout = to;
    @(negedge clk);
    wrValid = 1'b0; windowTimeout = 1'b0;
    gotPermit = wrPermit;
    gotConsumed = cmdConsumed;
  endtask

  task automatic timeoutPulse();
    @(negedge clk); windowTimeout = 1'b1;
    @(negedge clk); windowTimeout = 1'b0;
  endtask

  task automatic unlock(input logic p, input string req);
    wr({p, 12'h555}, 8'hAA); check({req, " cmd1 consumed"}, gotConsumed, 1);
    wr({p, 12'hAAA}, 8'h55); check({req, " cmd2 consumed"}, gotConsumed, 1);
    wr({p, 12'h555}, 8'hA0); check({req, " cmd3 consumed"}, gotConsumed, 1);
    check({req, " no permit on cmd"}, gotPermit, 0);
  endtask

  task automatic testReset();
    check("R1 permit", wrPermit, 0);
    check("R1 consumed", cmdConsumed, 0);
    check("R1 bpReg", bpReg, 8'h00);
    check("R1 sticky", dropSticky, 0);
  endtask

  task automatic testNoUnlock();
    wr(13'h0123, 8'h5A);
    check("R2 permit", gotPermit, 0);
    check("R2 consumed", gotConsumed, 0);
  endtask

  task automatic testUnlockPage();
    unlock(1'b0, "R3");
    wr(13'h0010, 8'h11);
    check("R3 permit1", gotPermit, 1);
    check("R3 addr", wrAddrOut, 13'h0010);
    check("R3 data", wrDataOut, 8'h11);
    wr(13'h0020, 8'h22);
    check("R3 permit2", gotPermit, 1);
    check("R3 data2", wrDataOut, 8'h22);
    timeoutPulse();
  endtask

  task automatic testPlane();
    unlock(1'b1, "R4 plane1");
    wr(13'h1234, 8'h33);
    check("R4 plane1 permit", gotPermit, 1);
    wr(13'h0100, 8'h44);
    check("R4 other plane rejected", gotPermit, 0);
    wr(13'h1238, 8'h55);
    check("R4 session closed", gotPermit, 0);
    wr(13'h0555, 8'hAA);
    wr(13'h1AAA, 8'h55);
    check("R4 mixed plane cmd", gotConsumed, 0);
    timeoutPulse();
  endtask

  task automatic testMismatch();
    wr(13'h0555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h0555, 8'h77);
    check("R5 bad byte consumed", gotConsumed, 0);
    check("R5 bad byte permit", gotPermit, 0);
    wr(13'h0040, 8'h66);
    check("R5 back to idle", gotPermit, 0);
  endtask

  task automatic testTimeout();
    wr(13'h0555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    timeoutPulse();
    wr(13'h0555, 8'hA0);
    check("R6 lost sequence", gotConsumed, 0);
    unlock(1'b0, "R6 pre");
    wr(13'h0555, 8'hAA, 1'b1);
    check("R6 same-cycle write from idle", gotConsumed, 1);
    wr(13'h0AAA, 8'h55);
    wr(13'h0555, 8'hA0);
    wr(13'h0050, 8'h77);
    check("R6 restart unlock works", gotPermit, 1);
    timeoutPulse();
  endtask

  task automatic testBpLoad();
    unlock(1'b0, "R7");
    wr(13'h0AAA, 8'h55); check("R7 ext4 consumed", gotConsumed, 1);
    wr(13'h0555, 8'h80); check("R7 ext5 consumed", gotConsumed, 1);
    check("R7 bp unchanged before load", bpReg, 8'h00);
    wr(13'h0000, 8'h05);
    check("R7 load consumed", gotConsumed, 1);
    check("R7 load not permitted", gotPermit, 0);
    check("R7 bpReg", bpReg, 8'h05);
    wr(13'h0400, 8'h99);
    check("R12 idle after load", gotPermit, 0);
  endtask

  task automatic testLock();
    unlock(1'b0, "R8");
    wr(13'h0000, 8'h12);
    check("R8 locked block dropped", gotPermit, 0);
    check("R8 sticky set", dropSticky, 1);
    wr(13'h0400, 8'h34);
    check("R8 unlocked block permit", gotPermit, 1);
    check("R8 unlocked addr", wrAddrOut, 13'h0400);
    wr(13'h0800, 8'h56);
    check("R8 block2 dropped", gotPermit, 0);
    timeoutPulse();
  endtask

  task automatic testWc();
    unlock(1'b0, "R9");
    wr(13'h0404, 8'h01);
    check("R9 before wc permit", gotPermit, 1);
    @(negedge clk); wrCtrl = 1'b1;
    wr(13'h0408, 8'h02);
    check("R9 wc write suppressed", gotPermit, 0);
    wr(13'h0555, 8'hAA);
    check("R9 wc cmd suppressed", gotConsumed, 0);
    @(negedge clk); wrCtrl = 1'b0;
    wr(13'h040C, 8'h03);
    check("R10 page aborted", gotPermit, 0);
    unlock(1'b0, "R10");
    wr(13'h040C, 8'h03);
    check("R10 fresh unlock permit", gotPermit, 1);
    timeoutPulse();
  endtask

  task automatic testSticky();
    repeat (5) @(negedge clk);
    check("R11 sticky holds", dropSticky, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoUnlock();
    testUnlockPage();
    testPlane();
    testMismatch();
    testTimeout();
    testBpLoad();
    testLock();
    testWc();
    testSticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule